// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block drives one channel of a scatter-gather transfer engine. Once started, it reads a chain of 8-byte descriptors from memory through a 32-bit read port. The chain begins at a pointer built from a high word and a low word. Each descriptor yields one memory segment, given as a 32-bit address and a 16-bit byte count. The walker hands each segment to a separate data mover as a command over a valid/ready handshake.

The walker stops in one of two ways. A descriptor whose end-of-list flag is set finishes the chain, and the walker reports success with a single-cycle pulse. A malformed descriptor ends the walk early and sets an error flag. A stop input aborts the walk at any point. The data mover, the memory and the register interface that sets up the pointer are outside this block.

Top module: `sg_walker`

## Requirements
- R1: While reset is held and after it is released, `rd_req`, `cmd_valid`, `done` and `err` are all low until a start is accepted.
- R2: A start accepted in idle loads the pointer `{base_hi, base_lo}`. The head word of a descriptor is read at the pointer and its address word at pointer + 4. The next descriptor begins at pointer + 8.
- R3: The fields of the head word are: bit 0 valid, bit 1 end-of-list, bit 5 transfer, bits 31:16 byte count. Bits 15:8 and the other low bits are ignored. The address word is the segment address. A command carries the byte count in `cmd_len` and the segment address in `cmd_addr`.
- R4: Once raised, `cmd_valid` stays high with `cmd_addr` and `cmd_len` unchanged until `cmd_ready` is seen high, unless stop is asserted.
- R5: A head word with the valid bit clear ends the walk. The walker issues no command and no done, and `err` rises one cycle after that read is acknowledged. `err` stays high until the next accepted start, which clears it.
- R6: A valid head word whose byte count is not a multiple of 4 is treated like an invalid descriptor: `err` rises and the walk ends.
- R7: A valid, aligned descriptor with a byte count of zero, or with its transfer bit clear, issues no command and is not followed by a read of its address word. Its end-of-list bit is still honoured.
- R8: `done` is high for exactly one cycle. It follows the cycle in which the command of an end-of-list descriptor is accepted, or the head read of a skipped end-of-list descriptor. The walker is then idle.
- R9: When `stop` is high at a clock edge, the walker is idle after that edge. A read acknowledged in the same cycle is discarded, and no command, done or error results from it.
- R10: A start that arrives while a walk is in progress is ignored.
- R11: Once raised, `rd_req` stays high with `rd_addr` unchanged until `rd_ack` is seen high, unless stop is asserted. `rd_data` is taken in the cycle of `rd_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (honoured only while idle) |
| stop | input | 1 | Abort the walk and return to idle |
| base_hi | input | HI_W (32) | Upper part of the first descriptor pointer |
| base_lo | input | 32 | Lower part of the first descriptor pointer |
| rd_req | output | 1 | Read request to memory |
| rd_addr | output | 32+HI_W (64) | Byte address of the requested word |
| rd_ack | input | 1 | Read accepted; `rd_data` valid this cycle |
| rd_data | input | 32 | Returned memory word |
| cmd_valid | output | 1 | Segment command offered to the data mover |
| cmd_ready | input | 1 | Data mover accepts the command |
| cmd_addr | output | 32 | Segment start address |
| cmd_len | output | 16 | Segment byte count |
| done | output | 1 | One-cycle pulse when the list completes |
| err | output | 1 | Sticky malformed-descriptor flag |

## Verification
Two functions can coincide in one cycle: the abort path and the completion of a memory read or command handshake. The bench raises `stop` in the same cycle that it acknowledges a head-word read. It also raises `stop` while a command is pending with `cmd_ready` held low. It then checks that the fetched word leaves no trace: no later read, no command, no done and no error. A start that arrives in the middle of a walk, pointing at a malformed list, is also injected. The walk must finish on its original list. A behavioural reference model runs alongside and judges every output on every cycle.

// File: rtl/sgw_pkg.sv
`timescale 1ns/1ps
package sgw_pkg;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 16;
    localparam int DESC_BYTES = 8;
    localparam int WORD_BYTES = 4;
    localparam int F_VALID    = 0;
    localparam int F_LAST     = 1;
    localparam int F_XFER     = 5;
    localparam int LEN_LSB    = 16;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_HEAD,
        WALK_ADDR,
        WALK_CMD
    } walk_st_e;

    typedef enum logic [1:0] {
        ACT_BAD,
        ACT_SKIP,
        ACT_MOVE
    } head_act_e;

    typedef struct packed {
        logic             valid;
        logic             last;
        logic             xfer;
        logic [LEN_W-1:0] len;
    } head_t;

    function automatic head_t unpack_head(input logic [WORD_W-1:0] w);
        head_t h;
        h.valid = w[F_VALID];
        h.last  = w[F_LAST];
        h.xfer  = w[F_XFER];
        h.len   = w[LEN_LSB +: LEN_W];
        return h;
    endfunction

    function automatic head_act_e classify(input head_t h);
        if (!h.valid || (h.len[1:0] != 2'b00))
            return ACT_BAD;
        else if (!h.xfer || (h.len == '0))
            return ACT_SKIP;
        else
            return ACT_MOVE;
    endfunction
endpackage

// File: rtl/sgw_ptr.sv
`timescale 1ns/1ps
module sgw_ptr
    import sgw_pkg::*;
#(
    parameter int PTR_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [PTR_W-1:0] base_i,
    input  logic             step_i,
    input  logic             hi_word_i,
    output logic [PTR_W-1:0] addr_o
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);
    localparam logic [PTR_W-1:0] OFF  = PTR_W'(WORD_BYTES);

    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (load_i)
            ptr_q <= base_i;
        else if (step_i)
            ptr_q <= ptr_q + STEP;
    end

    assign addr_o = ptr_q + (hi_word_i ? OFF : '0);
endmodule

// File: rtl/sgw_desc.sv
`timescale 1ns/1ps
module sgw_desc
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rdata_i,
    input  logic              cap_head_i,
    input  logic              cap_addr_i,
    output head_t             head_now_o,
    output logic              last_q_o,
    output logic [LEN_W-1:0]  len_q_o,
    output logic [WORD_W-1:0] addr_q_o
);
    head_t head_q;

    assign head_now_o = unpack_head(rdata_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q   <= '0;
            addr_q_o <= '0;
        end else begin
            if (cap_head_i)
                head_q <= head_now_o;
            if (cap_addr_i)
                addr_q_o <= rdata_i;
        end
    end

    assign last_q_o = head_q.last;
    assign len_q_o  = head_q.len;
endmodule

// File: rtl/sgw_fsm.sv
`timescale 1ns/1ps
module sgw_fsm
    import sgw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      stop_i,
    input  logic      rd_ack_i,
    input  head_act_e act_i,
    input  logic      head_last_i,
    input  logic      last_q_i,
    input  logic      cmd_ready_i,
    output logic      rd_req_o,
    output logic      hi_word_o,
    output logic      load_o,
    output logic      step_o,
    output logic      cap_head_o,
    output logic      cap_addr_o,
    output logic      cmd_valid_o,
    output logic      done_o,
    output logic      err_o
);
    walk_st_e st_q, st_d;
    logic     done_d, err_set;

    always_comb begin
        st_d       = st_q;
        load_o     = 1'b0;
        step_o     = 1'b0;
        cap_head_o = 1'b0;
        cap_addr_o = 1'b0;
        done_d     = 1'b0;
        err_set    = 1'b0;
        unique case (st_q)
            WALK_IDLE: begin
                if (start_i) begin
                    load_o = 1'b1;
                    st_d   = WALK_HEAD;
                end
            end
            WALK_HEAD: begin
                if (rd_ack_i) begin
                    cap_head_o = 1'b1;
                    unique case (act_i)
                        ACT_BAD: begin
                            err_set = 1'b1;
                            st_d    = WALK_IDLE;
                        end
                        ACT_SKIP: begin
                            if (head_last_i) begin
                                done_d = 1'b1;
                                st_d   = WALK_IDLE;
                            end else begin
                                step_o = 1'b1;
                            end
                        end
                        default: st_d = WALK_ADDR;
                    endcase
                end
            end
            WALK_ADDR: begin
                if (rd_ack_i) begin
                    cap_addr_o = 1'b1;
                    st_d       = WALK_CMD;
                end
            end
            WALK_CMD: begin
                if (cmd_ready_i) begin
                    if (last_q_i) begin
                        done_d = 1'b1;
                        st_d   = WALK_IDLE;
                    end else begin
                        step_o = 1'b1;
                        st_d   = WALK_HEAD;
                    end
                end
            end
            default: st_d = WALK_IDLE;
        endcase
        if (stop_i) begin
            st_d       = WALK_IDLE;
            load_o     = 1'b0;
            step_o     = 1'b0;
            cap_head_o = 1'b0;
            cap_addr_o = 1'b0;
            done_d     = 1'b0;
            err_set    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WALK_IDLE;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_o <= done_d;
            if (load_o)
                err_o <= 1'b0;
            else if (err_set)
                err_o <= 1'b1;
        end
    end

    assign rd_req_o    = (st_q == WALK_HEAD) || (st_q == WALK_ADDR);
    assign hi_word_o   = (st_q == WALK_ADDR);
    assign cmd_valid_o = (st_q == WALK_CMD);
endmodule

// File: rtl/sg_walker.sv
`timescale 1ns/1ps
module sg_walker
    import sgw_pkg::*;
#(
    parameter int HI_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 stop,
    input  logic [HI_W-1:0]      base_hi,
    input  logic [WORD_W-1:0]    base_lo,
    output logic                 rd_req,
    output logic [WORD_W+HI_W-1:0] rd_addr,
    input  logic                 rd_ack,
    input  logic [WORD_W-1:0]    rd_data,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [WORD_W-1:0]    cmd_addr,
    output logic [LEN_W-1:0]     cmd_len,
    output logic                 done,
    output logic                 err
);
    localparam int PTR_W = WORD_W + HI_W;

    logic      load, step, hi_word, cap_head, cap_addr, last_q;
    head_t     head_now;
    head_act_e act;

    assign act = classify(head_now);

    sgw_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .base_i   ({base_hi, base_lo}),
        .step_i   (step),
        .hi_word_i(hi_word),
        .addr_o   (rd_addr)
    );

    sgw_desc u_desc (
        .clk       (clk),
        .rst       (rst),
        .rdata_i   (rd_data),
        .cap_head_i(cap_head),
        .cap_addr_i(cap_addr),
        .head_now_o(head_now),
        .last_q_o  (last_q),
        .len_q_o   (cmd_len),
        .addr_q_o  (cmd_addr)
    );

    sgw_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .stop_i     (stop),
        .rd_ack_i   (rd_ack),
        .act_i      (act),
        .head_last_i(head_now.last),
        .last_q_i   (last_q),
        .cmd_ready_i(cmd_ready),
        .rd_req_o   (rd_req),
        .hi_word_o  (hi_word),
        .load_o     (load),
        .step_o     (step),
        .cap_head_o (cap_head),
        .cap_addr_o (cap_addr),
        .cmd_valid_o(cmd_valid),
        .done_o     (done),
        .err_o      (err)
    );
endmodule

// File: rtl/sgw_checker.sv
`timescale 1ns/1ps
module sgw_checker #(
    parameter int PTR_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             stop,
    input logic             rd_req,
    input logic [PTR_W-1:0] rd_addr,
    input logic             rd_ack,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [31:0]      cmd_addr,
    input logic [15:0]      cmd_len,
    input logic             done,
    input logic             err
);
    a_r4_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready && !stop |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));

    a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ack && !stop |=> rd_req && $stable(rd_addr));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_stop_idle: assert property (@(posedge clk) disable iff (rst)
        stop |=> !rd_req && !cmd_valid && !done);

    a_r6_len_legal: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_len[1:0] == 2'b00) && (cmd_len != 16'd0));

    a_r5_no_done_on_err: assert property (@(posedge clk) disable iff (rst)
        done |-> !err);

    a_r2_one_side: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && cmd_valid));
endmodule

bind sg_walker sgw_checker #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stop     (stop),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ack   (rd_ack),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_addr (cmd_addr),
    .cmd_len  (cmd_len),
    .done     (done),
    .err      (err)
);

// File: tb/sim_sg_walker.sv
`timescale 1ns/1ps
module sim_sg_walker;
    logic        clk = 1'b0;
    logic        rst_r = 1'b1;
    logic        start_r = 1'b0, stop_r = 1'b0, ack_r = 1'b0, ready_r = 1'b0;
    logic [31:0] base_hi_r = 32'h0000_0001;
    logic [31:0] base_lo_r = 32'h0;
    logic [31:0] rdata_r = 32'h0;

    logic        rd_req, cmd_valid, done, err;
    logic [63:0] rd_addr;
    logic [31:0] cmd_addr;
    logic [15:0] cmd_len;

    logic [31:0] mem [0:255];

    int n_chk = 0, n_fail = 0, n_acc = 0, n_done = 0;

    int          m_ph = 0;
    logic [63:0] m_ptr = '0;
    logic        m_last = 1'b0, m_done = 1'b0, m_err = 1'b0;
    logic [15:0] m_len = '0;
    logic [31:0] m_addr = '0;

    always #4 clk = ~clk;

    sg_walker u0 (
        .clk(clk), .rst(rst_r), .start(start_r), .stop(stop_r),
        .base_hi(base_hi_r), .base_lo(base_lo_r),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(ack_r), .rd_data(rdata_r),
        .cmd_valid(cmd_valid), .cmd_ready(ready_r), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .done(done), .err(err)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst_r) begin
            m_ph = 0; m_ptr = '0; m_done = 1'b0; m_err = 1'b0; m_last = 1'b0;
        end else begin
            m_done = 1'b0;
            if (stop_r) begin
                m_ph = 0;
            end else if (m_ph == 0) begin
                if (start_r) begin
                    m_ptr = {base_hi_r, base_lo_r};
                    m_err = 1'b0;
                    m_ph  = 1;
                end
            end else if (m_ph == 1) begin
                if (ack_r) begin
                    if (!rdata_r[0] || rdata_r[17:16] != 2'b00) begin
                        m_err = 1'b1; m_ph = 0;
                    end else if (!rdata_r[5] || rdata_r[31:16] == 16'd0) begin
                        if (rdata_r[1]) begin m_done = 1'b1; m_ph = 0; end
                        else m_ptr = m_ptr + 64'd8;
                    end else begin
                        m_last = rdata_r[1]; m_len = rdata_r[31:16]; m_ph = 2;
                    end
                end
            end else if (m_ph == 2) begin
                if (ack_r) begin m_addr = rdata_r; m_ph = 3; end
            end else begin
                if (ready_r) begin
                    if (m_last) begin m_done = 1'b1; m_ph = 0; end
                    else begin m_ptr = m_ptr + 64'd8; m_ph = 1; end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic        e_req;
        logic [63:0] e_addr;
        e_req  = (m_ph == 1) || (m_ph == 2);
        e_addr = m_ptr + ((m_ph == 2) ? 64'd4 : 64'd0);
        chk(rd_req == e_req, "R11 rd_req", longint'(rd_req), longint'(e_req));
        if (e_req) chk(rd_addr == e_addr, "R2 rd_addr", longint'(rd_addr), longint'(e_addr));
        chk(cmd_valid == (m_ph == 3), "R4 cmd_valid", longint'(cmd_valid), longint'(m_ph == 3));
        if (m_ph == 3) begin
            chk(cmd_addr == m_addr, "R3 cmd_addr", longint'(cmd_addr), longint'(m_addr));
            chk(cmd_len == m_len, "R3 cmd_len", longint'(cmd_len), longint'(m_len));
        end
        chk(done == m_done, "R8 done", longint'(done), longint'(m_done));
        chk(err == m_err, "R5 err", longint'(err), longint'(m_err));
    endtask

    // am / rm: 0 random, 1 forced high, 2 forced low
    task automatic tick(input bit st, input bit sp, input int am, input int rm);
        @(negedge clk);
        if (!rst_r) compare();
        if (done) n_done++;
        start_r = st;
        stop_r  = sp;
        ack_r   = rd_req && (am == 1 || (am == 0 && $urandom_range(0, 2) == 0));
        rdata_r = mem[rd_addr[9:2]];
        ready_r = (rm == 1) || (rm == 0 && $urandom_range(0, 1) == 1);
        if (cmd_valid && ready_r) n_acc++;
    endtask

    task automatic put_desc(input int off, input bit v, input bit lst, input bit x,
                            input logic [15:0] len, input logic [31:0] a);
        logic [31:0] w;
        w = {len, 8'h00, 8'h00};
        w[0] = v; w[1] = lst; w[5] = x;
        mem[off >> 2]       = w;
        mem[(off >> 2) + 1] = a;
    endtask

    task automatic finish_walk();
        for (int i = 0; i < 600; i++) begin
            tick(0, 0, 0, 0);
            if (m_ph == 0) break;
        end
        repeat (3) tick(0, 0, 0, 0);
    endtask

    task automatic run_walk(input logic [31:0] lo, input int e_acc, input int e_done,
                            input bit e_err, input string tag);
        n_acc = 0; n_done = 0;
        base_lo_r = lo;
        tick(1, 0, 0, 0);
        finish_walk();
        chk(n_acc == e_acc, {tag, " commands"}, longint'(n_acc), longint'(e_acc));
        chk(n_done == e_done, {tag, " done count"}, longint'(n_done), longint'(e_done));
        chk(err == e_err, {tag, " err"}, longint'(err), longint'(e_err));
    endtask

    initial begin
        #1200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        // list A: move, zero-length skip, non-transfer skip, last move
        put_desc(32'h040, 1, 0, 1, 16'd16,     32'h0000_1000);
        put_desc(32'h048, 1, 0, 1, 16'd0,      32'h1111_1111);
        put_desc(32'h050, 1, 0, 0, 16'd8,      32'h2222_2222);
        put_desc(32'h058, 1, 1, 1, 16'hFFFC,   32'hDEAD_BEEC);
        // list B: move then invalid
        put_desc(32'h100, 1, 0, 1, 16'd32,     32'h0000_2000);
        put_desc(32'h108, 0, 1, 1, 16'd4,      32'h0000_3000);
        // list C: misaligned length
        put_desc(32'h180, 1, 1, 1, 16'd6,      32'h0000_4000);
        // list D: single skipped last descriptor
        put_desc(32'h200, 1, 1, 0, 16'd12,     32'h0000_5000);

        repeat (3) tick(0, 0, 0, 0);
        // R1: outputs idle during reset
        chk(!rd_req && !cmd_valid && !done && !err, "R1 reset idle", longint'({rd_req, cmd_valid, done, err}), 0);
        @(negedge clk); rst_r = 1'b0;
        tick(0, 0, 0, 0);
        chk(!rd_req && !cmd_valid && !done && !err, "R1 after release", longint'({rd_req, cmd_valid, done, err}), 0);

        run_walk(32'h040, 2, 1, 0, "R7 R8 list A");
        run_walk(32'h100, 1, 0, 1, "R5 invalid");
        run_walk(32'h180, 0, 0, 1, "R6 misaligned");
        run_walk(32'h040, 2, 1, 0, "R5 err cleared by start");
        run_walk(32'h200, 0, 1, 0, "R7 skipped last");

        // R9: stop coinciding with a head read acknowledge
        n_acc = 0; n_done = 0; base_lo_r = 32'h040;
        tick(1, 0, 0, 2);
        tick(0, 1, 1, 2);
        tick(0, 0, 0, 0);
        chk(!rd_req && !cmd_valid, "R9 idle after stop+ack", longint'({rd_req, cmd_valid}), 0);
        repeat (6) tick(0, 0, 0, 0);
        chk(n_acc == 0 && n_done == 0 && !err, "R9 fetch discarded", longint'(n_acc + n_done), 0);

        // R9: stop while a command waits
        tick(1, 0, 1, 2);
        for (int i = 0; i < 20; i++) begin
            tick(0, 0, 1, 2);
            if (m_ph == 3) break;
        end
        chk(cmd_valid, "R9 command pending before stop", longint'(cmd_valid), 1);
        tick(0, 1, 0, 2);
        repeat (5) tick(0, 0, 0, 0);
        chk(!cmd_valid && n_acc == 0 && n_done == 0, "R9 command withdrawn", longint'(n_acc), 0);

        // R10: start mid-walk pointing at a malformed list is ignored
        n_acc = 0; n_done = 0; base_lo_r = 32'h040;
        tick(1, 0, 0, 0);
        tick(0, 0, 0, 0);
        base_lo_r = 32'h180;
        tick(1, 0, 0, 0);
        tick(1, 0, 0, 0);
        finish_walk();
        chk(n_acc == 2 && n_done == 1 && !err, "R10 busy start ignored", longint'(n_acc), 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule